// File: doc/BRIEF.md
# Transport Stream Input Receiver

This block sits behind a cable demodulator and its error-correction stage and turns the incoming MPEG-2 transport stream into whole 188-byte packets. The upstream stage supplies a byte (or bit) clock, a data bus and one framing strobe. The receiver samples all three with its own faster system clock and finds the active edges of the incoming clock. It then rebuilds bytes and emits them as a stream with valid, start-of-packet and end-of-packet flags.

Three configuration bits, held steady while the block runs, set how it works:

- The interface width: eight parallel lines, or one serial line on bus bit 0.
- The meaning of the strobe: a pulse that marks the sync byte, or an enable that covers the payload bytes and drops out for the trailing redundancy bytes.
- Which incoming clock edge captures data.

Packets that open with a wrong sync value are dropped and raise a sticky error. Packets cut short by an early new start are flagged on the next start-of-packet.

Top module: `tsin_receiver`

## Requirements
- R1: With `cfg_serial`=0, each active edge of `ts_clk` captures `ts_data[7:0]` as one byte, with bit 7 as the most significant bit, and that value appears unchanged on `out_data`.
- R2: With `cfg_serial`=1, only `ts_data[0]` is used and `ts_data[7:1]` have no effect on any output. Bits are shifted in most significant first. A byte is complete on the 8th active edge counted from the bit that realigns the shifter: the strobe bit in pulse mode, or the first strobe-high bit after a low one in enable mode.
- R3: With `cfg_strobe_en`=0 (pulse mode), a packet starts at the byte captured while `ts_strobe` is high, in parallel mode, or at the byte whose first bit had `ts_strobe` high, in serial mode.
- R4: With `cfg_strobe_en`=1 (enable mode), a packet starts at the first strobe-high byte after a strobe-low byte or after reset. Bytes captured with `ts_strobe` low are discarded.
- R5: With `cfg_clk_fall`=0 data is captured on rising edges of `ts_clk`; with `cfg_clk_fall`=1 it is captured on falling edges.
- R6: The first byte of a packet (value 0x47) is output with `out_sop`=1, and byte number 188 with `out_eop`=1. `out_sop` and `out_eop` are never high without `out_valid`.
- R7: If a packet start carries a byte other than 0x47, no byte of that packet is output, `sync_err` goes to 1 and stays there until reset, and `sync_lost` stays 1 until a start with 0x47 arrives.
- R8: A valid start that arrives while a packet has fewer than 188 bytes restarts the count. `pkt_short` pulses together with the new `out_sop`.
- R9: After reset, `out_valid`, `out_sop`, `out_eop`, `pkt_short` and `sync_err` are 0 and `sync_lost` is 1.
- R10: Bytes that arrive after end-of-packet and before the next packet start are not output, even if their value is 0x47.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than twice the incoming bit or byte rate |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_serial | input | 1 | 0 selects 8-bit parallel input, 1 selects serial input on bit 0 |
| cfg_strobe_en | input | 1 | 0 selects pulse framing, 1 selects enable framing |
| cfg_clk_fall | input | 1 | 0 captures on rising edges of ts_clk, 1 on falling edges |
| ts_clk | input | 1 | Incoming byte or bit clock |
| ts_data | input | 8 | Incoming data bus |
| ts_strobe | input | 1 | Framing strobe (sync pulse or data enable) |
| out_data | output | 8 | Packet byte |
| out_valid | output | 1 | out_data holds a packet byte this cycle |
| out_sop | output | 1 | Byte is the first of a packet |
| out_eop | output | 1 | Byte is the 188th of a packet |
| pkt_short | output | 1 | Previous packet ended before 188 bytes |
| sync_err | output | 1 | Sticky: a packet start carried a wrong sync value |
| sync_lost | output | 1 | No valid packet start seen since reset or since the last bad one |

## Verification
The assertions assume that the configuration bits stay fixed between resets. They also assume that `ts_clk` stays at each level for at least two system clocks, so that the synchronizer never misses an edge. The assumption that matters most is that the data and strobe lines are steady around every active edge; the byte-length and sync-value properties depend on capturing the right sample. The stimulus changes data and strobe only while the incoming clock sits at its inactive level. It holds each level for three system clocks and changes configuration only while reset is asserted.

// File: rtl/tsin_pkg.sv
package tsin_pkg;
   localparam logic [7:0] TS_SYNC_VALUE = 8'h47;
   localparam int unsigned TS_BYTE_W    = 8;

   typedef struct packed {
      logic [TS_BYTE_W-1:0] data;
      logic                 strb;
   } ts_beat_t;
endpackage

// File: rtl/tsin_sync.sv
module tsin_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fall_sel,
   input  logic       clk_in,
   input  logic [7:0] data_in,
   input  logic       strb_in,
   output logic       edge_hit,
   output logic [7:0] data_q,
   output logic       strb_q
);
   localparam int unsigned VW = 10;

   if (STAGES < 2) begin : g_bad_stages
      $error("tsin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][VW-1:0] chain;
   logic                      clk_last;
   logic                      clk_now;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain    <= '0;
         clk_last <= 1'b0;
      end else begin
         chain[0] <= {clk_in, strb_in, data_in};
         for (int i = 1; i < int'(STAGES); i++) begin
            chain[i] <= chain[i-1];
         end
         clk_last <= chain[STAGES-1][VW-1];
      end
   end

   assign clk_now  = chain[STAGES-1][VW-1];
   assign strb_q   = chain[STAGES-1][VW-2];
   assign data_q   = chain[STAGES-1][VW-3:0];
   assign edge_hit = fall_sel ? (clk_last & ~clk_now) : (~clk_last & clk_now);
endmodule

// File: rtl/tsin_deser.sv
module tsin_deser
   import tsin_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       serial_mode,
   input  logic       enable_mode,
   input  logic       edge_hit,
   input  logic [7:0] data_q,
   input  logic       strb_q,
   output logic       beat_vld,
   output ts_beat_t   beat
);
   localparam int unsigned BIT_CW = $clog2(TS_BYTE_W);

   logic [BIT_CW-1:0]    bit_cnt;
   logic [TS_BYTE_W-2:0] shreg;
   logic                 first_strb;
   logic                 prev_bit_strb;
   logic                 realign;

   assign realign = enable_mode ? (strb_q & ~prev_bit_strb) : strb_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_cnt       <= '0;
         shreg         <= '0;
         first_strb    <= 1'b0;
         prev_bit_strb <= 1'b0;
         beat_vld      <= 1'b0;
         beat          <= '0;
      end else begin
         beat_vld <= 1'b0;
         if (edge_hit) begin
            prev_bit_strb <= strb_q;
            if (!serial_mode) begin
               beat_vld  <= 1'b1;
               beat.data <= data_q;
               beat.strb <= strb_q;
            end else if (realign) begin
               shreg      <= {{(TS_BYTE_W-2){1'b0}}, data_q[0]};
               bit_cnt    <= BIT_CW'(1);
               first_strb <= strb_q;
            end else begin
               shreg   <= {shreg[TS_BYTE_W-3:0], data_q[0]};
               bit_cnt <= bit_cnt + BIT_CW'(1);
               if (bit_cnt == '0) begin
                  first_strb <= strb_q;
               end
               if (bit_cnt == BIT_CW'(TS_BYTE_W-1)) begin
                  beat_vld  <= 1'b1;
                  beat.data <= {shreg, data_q[0]};
                  beat.strb <= first_strb;
               end
            end
         end
      end
   end
endmodule

// File: rtl/tsin_framer.sv
module tsin_framer
   import tsin_pkg::*;
#(
   parameter int unsigned PKT_LEN = 188
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enable_mode,
   input  logic       beat_vld,
   input  ts_beat_t   beat,
   output logic [7:0] out_data,
   output logic       out_valid,
   output logic       out_sop,
   output logic       out_eop,
   output logic       pkt_short,
   output logic       sync_err,
   output logic       sync_lost
);
   localparam int unsigned CNT_W = $clog2(PKT_LEN);

   if (PKT_LEN < 2) begin : g_bad_len
      $error("tsin_framer: PKT_LEN must be at least 2");
   end

   logic [CNT_W-1:0] cnt;
   logic             in_pkt;
   logic             prev_strb;
   logic             start;
   logic             keep;

   assign start = enable_mode ? (beat.strb & ~prev_strb) : beat.strb;
   assign keep  = ~enable_mode | beat.strb;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt       <= '0;
         in_pkt    <= 1'b0;
         prev_strb <= 1'b0;
         out_data  <= '0;
         out_valid <= 1'b0;
         out_sop   <= 1'b0;
         out_eop   <= 1'b0;
         pkt_short <= 1'b0;
         sync_err  <= 1'b0;
         sync_lost <= 1'b1;
      end else begin
         out_valid <= 1'b0;
         out_sop   <= 1'b0;
         out_eop   <= 1'b0;
         pkt_short <= 1'b0;
         if (beat_vld) begin
            prev_strb <= beat.strb;
            if (start) begin
               if (beat.data == TS_SYNC_VALUE) begin
                  out_valid <= 1'b1;
                  out_sop   <= 1'b1;
                  out_data  <= beat.data;
                  pkt_short <= in_pkt;
                  in_pkt    <= 1'b1;
                  cnt       <= CNT_W'(1);
                  sync_lost <= 1'b0;
               end else begin
                  sync_err  <= 1'b1;
                  sync_lost <= 1'b1;
                  in_pkt    <= 1'b0;
               end
            end else if (in_pkt && keep) begin
               out_valid <= 1'b1;
               out_data  <= beat.data;
               cnt       <= cnt + CNT_W'(1);
               if (cnt == CNT_W'(PKT_LEN-1)) begin
                  out_eop <= 1'b1;
                  in_pkt  <= 1'b0;
               end
            end
         end
      end
   end
endmodule

// File: rtl/tsin_receiver.sv
module tsin_receiver
   import tsin_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned PKT_LEN     = 188
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_serial,
   input  logic       cfg_strobe_en,
   input  logic       cfg_clk_fall,
   input  logic       ts_clk,
   input  logic [7:0] ts_data,
   input  logic       ts_strobe,
   output logic [7:0] out_data,
   output logic       out_valid,
   output logic       out_sop,
   output logic       out_eop,
   output logic       pkt_short,
   output logic       sync_err,
   output logic       sync_lost
);
   logic       edge_hit;
   logic [7:0] data_q;
   logic       strb_q;
   logic       beat_vld;
   ts_beat_t   beat;

   tsin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .fall_sel (cfg_clk_fall),
      .clk_in   (ts_clk),
      .data_in  (ts_data),
      .strb_in  (ts_strobe),
      .edge_hit (edge_hit),
      .data_q   (data_q),
      .strb_q   (strb_q)
   );

   tsin_deser u_deser (
      .clk         (clk),
      .rst_n       (rst_n),
      .serial_mode (cfg_serial),
      .enable_mode (cfg_strobe_en),
      .edge_hit    (edge_hit),
      .data_q      (data_q),
      .strb_q      (strb_q),
      .beat_vld    (beat_vld),
      .beat        (beat)
   );

   tsin_framer #(.PKT_LEN(PKT_LEN)) u_framer (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable_mode (cfg_strobe_en),
      .beat_vld    (beat_vld),
      .beat        (beat),
      .out_data    (out_data),
      .out_valid   (out_valid),
      .out_sop     (out_sop),
      .out_eop     (out_eop),
      .pkt_short   (pkt_short),
      .sync_err    (sync_err),
      .sync_lost   (sync_lost)
   );
endmodule

// File: rtl/tsin_receiver_chk.sv
module tsin_receiver_chk #(
   parameter int unsigned PKT_LEN = 188
) (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] out_data,
   input logic       out_valid,
   input logic       out_sop,
   input logic       out_eop,
   input logic       pkt_short,
   input logic       sync_err,
   input logic       sync_lost
);
   localparam int unsigned CW = $clog2(PKT_LEN);

   logic [CW-1:0] seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen <= '0;
      end else if (out_valid) begin
         seen <= out_sop ? CW'(1) : seen + CW'(1);
      end
   end

   p_sop_is_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_sop |-> out_data == 8'h47);
   p_flags_need_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> !out_sop && !out_eop);
   p_eop_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_eop && !out_sop |-> seen == CW'(PKT_LEN-1));
   p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sync_err |=> sync_err);
   p_out_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !sync_lost);
   p_short_with_sop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_short |-> out_valid && out_sop);
endmodule

bind tsin_receiver tsin_receiver_chk #(.PKT_LEN(PKT_LEN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .out_data  (out_data),
   .out_valid (out_valid),
   .out_sop   (out_sop),
   .out_eop   (out_eop),
   .pkt_short (pkt_short),
   .sync_err  (sync_err),
   .sync_lost (sync_lost)
);

// File: tb/tsin_receiver_test.sv
module tsin_receiver_test;
   localparam int HP = 3;
   localparam int PL = 188;
   localparam int NROW = 6;
   // {serial, strobe_en, clk_fall, npk[2:0], red[5:0]}
   localparam logic [11:0] VEC [NROW] = '{
      {1'b0, 1'b0, 1'b0, 3'd2, 6'd4},
      {1'b0, 1'b1, 1'b1, 3'd2, 6'd16},
      {1'b1, 1'b0, 1'b0, 3'd2, 6'd3},
      {1'b1, 1'b1, 1'b0, 3'd2, 6'd2},
      {1'b1, 1'b0, 1'b1, 3'd1, 6'd0},
      {1'b0, 1'b1, 1'b0, 3'd2, 6'd8}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_serial = 1'b0, cfg_strobe_en = 1'b0, cfg_clk_fall = 1'b0;
   logic ts_clk = 1'b0;
   logic [7:0] ts_data = '0;
   logic ts_strobe = 1'b0;
   logic [7:0] out_data;
   logic out_valid, out_sop, out_eop, pkt_short, sync_err, sync_lost;

   int total = 0, bad = 0;
   logic [7:0] cap_d [1024];
   logic       cap_s [1024];
   logic       cap_e [1024];
   int ncap = 0, nshort = 0;

   always #5 clk = ~clk;

   tsin_receiver uut (
      .clk(clk), .rst_n(rst_n), .cfg_serial(cfg_serial), .cfg_strobe_en(cfg_strobe_en),
      .cfg_clk_fall(cfg_clk_fall), .ts_clk(ts_clk), .ts_data(ts_data), .ts_strobe(ts_strobe),
      .out_data(out_data), .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
      .pkt_short(pkt_short), .sync_err(sync_err), .sync_lost(sync_lost)
   );

   always @(negedge clk) begin
      if (rst_n && out_valid && ncap < 1024) begin
         cap_d[ncap] = out_data;
         cap_s[ncap] = out_sop;
         cap_e[ncap] = out_eop;
         ncap++;
      end
      if (rst_n && pkt_short) nshort++;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pbyte(input int seed, input int i);
      return (i == 0) ? 8'h47 : 8'((seed * 31 + i * 5 + 3) & 255);
   endfunction

   task automatic do_reset(input logic ser, input logic en, input logic fall);
      @(negedge clk);
      rst_n = 1'b0;
      cfg_serial = ser; cfg_strobe_en = en; cfg_clk_fall = fall;
      ts_clk = fall; ts_strobe = 1'b0; ts_data = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      ncap = 0; nshort = 0;
      repeat (4) @(negedge clk);
   endtask

   task automatic send_unit(input logic [7:0] d, input logic s);
      ts_data = d; ts_strobe = s;
      repeat (HP) @(negedge clk);
      ts_clk = ~cfg_clk_fall;
      repeat (HP) @(negedge clk);
      ts_clk = cfg_clk_fall;
   endtask

   // s_first: strobe on first bit; s_rest: strobe on the other bits (serial)
   task automatic send_byte(input logic [7:0] d, input logic s_first, input logic s_rest);
      if (!cfg_serial) begin
         send_unit(d, s_first);
      end else begin
         for (int b = 7; b >= 0; b--) begin
            send_unit({7'h2a, d[b]}, (b == 7) ? s_first : s_rest);
         end
      end
   endtask

   task automatic send_pkt(input int seed, input int len, input logic [7:0] first);
      for (int i = 0; i < len; i++) begin
         logic s1, s2;
         s1 = cfg_strobe_en ? 1'b1 : (i == 0);
         s2 = cfg_strobe_en;
         send_byte((i == 0) ? first : pbyte(seed, i), s1, s2);
      end
   endtask

   task automatic flush();
      repeat (20) @(negedge clk);
   endtask

   function automatic string row_tag(input int r);
      case (r)
         0: return "R1/R3/R6/R10 parallel pulse rising";
         1: return "R4/R5 parallel enable falling";
         2: return "R2/R3 serial pulse rising";
         3: return "R2/R4 serial enable rising";
         4: return "R5/R2 serial pulse falling";
         default: return "R4 parallel enable rising";
      endcase
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R9: reset state
      do_reset(1'b0, 1'b0, 1'b0);
      check(!out_valid && !out_sop && !out_eop && !pkt_short, "R9 idle outputs",
            int'({out_valid, out_sop, out_eop, pkt_short}), 0);
      check(sync_err == 1'b0, "R9 sync_err", int'(sync_err), 0);
      check(sync_lost == 1'b1, "R9 sync_lost", int'(sync_lost), 1);

      // Table walk: R1 R2 R3 R4 R5 R6 R10
      for (int r = 0; r < NROW; r++) begin
         logic [11:0] v;
         int npk, red, mism, fpos;
         v = VEC[r];
         npk = int'(v[8:6]);
         red = int'(v[5:0]);
         do_reset(v[11], v[10], v[9]);
         for (int p = 0; p < npk; p++) begin
            send_pkt(r * 8 + p, PL, 8'h47);
            for (int k = 0; k < red; k++) send_byte(8'h47, 1'b0, 1'b0);
         end
         flush();
         check(ncap == npk * PL, {row_tag(r), " byte count"}, ncap, npk * PL);
         mism = 0; fpos = 0;
         for (int i = 0; i < ncap && i < npk * PL; i++) begin
            if (cap_d[i] != pbyte(r * 8 + i / PL, i % PL)) mism++;
            if (cap_s[i] != ((i % PL) == 0) || cap_e[i] != ((i % PL) == PL - 1)) fpos++;
         end
         check(mism == 0, {row_tag(r), " data"}, mism, 0);
         check(fpos == 0, {row_tag(r), " sop/eop R6"}, fpos, 0);
         check(sync_err == 1'b0 && sync_lost == 1'b0, {row_tag(r), " status"},
               int'({sync_err, sync_lost}), 0);
      end

      // R7: wrong sync value drops packet, sticky error
      do_reset(1'b0, 1'b0, 1'b0);
      send_pkt(50, PL, 8'h12);
      flush();
      check(ncap == 0, "R7 bad packet dropped", ncap, 0);
      check(sync_err == 1'b1, "R7 sync_err set", int'(sync_err), 1);
      check(sync_lost == 1'b1, "R7 sync_lost held", int'(sync_lost), 1);
      send_pkt(51, PL, 8'h47);
      flush();
      check(ncap == PL, "R7 recovery count", ncap, PL);
      check(sync_err == 1'b1, "R7 sync_err sticky", int'(sync_err), 1);
      check(sync_lost == 1'b0, "R7 sync regained", int'(sync_lost), 0);

      // R8: short packet followed by a full one
      do_reset(1'b0, 1'b0, 1'b0);
      send_pkt(60, 50, 8'h47);
      send_pkt(61, PL, 8'h47);
      flush();
      check(ncap == 50 + PL, "R8 byte count", ncap, 50 + PL);
      check(nshort == 1, "R8 short flag", nshort, 1);
      check(ncap > 50 && cap_s[50] == 1'b1 && cap_s[0] == 1'b1, "R8 restart sop",
            (ncap > 50) ? int'(cap_s[50]) : 0, 1);
      begin
         int ne;
         ne = 0;
         for (int i = 0; i < ncap; i++) if (cap_e[i]) ne++;
         check(ne == 1 && cap_e[50 + PL - 1] == 1'b1, "R8 single eop", ne, 1);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule